// File: doc/BRIEF.md
# Posted-Write Address Window Router

This block sits on the write path between an AXI write slave and a downstream command port. Each write is routed by address. It can be sent as a posted write, which is acknowledged on the AXI B channel straight away. Otherwise it is sent as a non-posted write, whose B response waits for a completion from downstream. The choice is made by comparing the upper address bits [39:24] against two programmable windows. Each window has an enable flag, a base, a contiguous mask and a translation value.

A write that lands in an enabled window leaves as a posted command. Its upper bits are replaced by the translation value wherever the mask is one. The address bits below bit 24, and the upper bits the mask leaves clear, pass through unchanged. A write that misses every window leaves untranslated as a non-posted command. Only one non-posted write can be in flight, so new writes are held off until its completion returns. The windows are set up through a simple word-wide register port.

Top module: `post_win_router`

## Requirements
- R1: After reset every configuration register reads 0x00000000 and no window is enabled, so every write is routed non-posted.
- R2: The enable/translate word of window 0 is at offset 0xd0 and that of window 1 is at 0xd8. In this word the enable is bit 31 and the translation is bits 15:0. The base/mask word of window 0 is at 0xd4 and that of window 1 is at 0xdc. In this word the base is bits 31:16 and the mask is bits 15:0. Bits 30:16 of an enable/translate word always read zero, and writes to them are ignored.
- R3: A window hits when its enable is 1 and (base & mask) == (addr[39:24] & mask), where addr is the AXI write address as received.
- R4: A write that hits is issued with cmd_posted_o=1. Its B response (OKAY, 2'b00) is raised in the same cycle as the command and does not wait for cmd_ready_i.
- R5: A write that hits no window is issued with cmd_posted_o=0. b_valid_o stays low until cpl_valid_i is seen, and the B response then carries cpl_resp_i.
- R6: On a hit, cmd_addr_o[39:24] = (trans & mask) | (addr[39:24] & ~mask) and cmd_addr_o[23:0] = addr[23:0]. On a miss, cmd_addr_o equals the AXI address.
- R7: When both windows hit, window 0 supplies the translation.
- R8: aw_ready_o stays low while a command, a B response or a completion is pending. B responses are held until accepted.
- R9: cmd_data_o and cmd_strb_o carry the write beat unchanged. All command fields stay stable while cmd_valid_o is high and cmd_ready_i is low.
- R10: A window whose enable is 0 never hits, whatever its base and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| aw_addr_i | input | 40 | Write address |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| w_data_i | input | 64 | Write data beat |
| w_strb_i | input | 8 | Byte strobes |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| b_resp_o | output | 2 | Write response code |
| cmd_valid_o | output | 1 | Downstream command valid |
| cmd_ready_i | input | 1 | Downstream command ready |
| cmd_posted_o | output | 1 | 1 = posted write, 0 = non-posted |
| cmd_addr_o | output | 40 | Routed address |
| cmd_data_o | output | 64 | Data beat |
| cmd_strb_o | output | 8 | Byte strobes |
| cpl_valid_i | input | 1 | Downstream completion pulse |
| cpl_resp_i | input | 2 | Completion response code |

## Verification
Some properties are checked on every cycle. No B response is raised while a non-posted completion is pending. A posted command rises together with its B response. aw_ready_o stays low while work is in flight. Commands and responses hold steady under back-pressure. Reserved bits read zero. Other behaviour can only be shown by the bench's scenarios, because they depend on the register contents: the hit rule, the masked translation, the priority of window 0 when the windows overlap, and the effect of a disabled window. The bench programs random contiguous masks and predicts every routed address.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int ADDR_W = 40;
  localparam int HI_LSB = 24;
  localparam int HI_W   = ADDR_W - HI_LSB;

  typedef struct packed {
    logic            en;
    logic [HI_W-1:0] trans;
    logic [HI_W-1:0] base;
    logic [HI_W-1:0] mask;
  } win_cfg_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_pkg::*;
#(
  parameter int                 NWIN     = 2,
  parameter int                 CFG_AW   = 8,
  parameter logic [CFG_AW-1:0]  BASE_OFF = 8'hd0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [CFG_AW-1:0]            cfg_addr_i,
  input  logic [31:0]                  cfg_wdata_i,
  output logic [31:0]                  cfg_rdata_o,
  output win_cfg_t [NWIN-1:0]          cfg_o
);
  localparam int IDX_W = CFG_AW - 3;

  logic [CFG_AW-1:0] off;
  logic [IDX_W-1:0]  widx;
  logic              sel;

  assign off  = cfg_addr_i - BASE_OFF;
  assign widx = off[CFG_AW-1:3];
  assign sel  = (cfg_addr_i >= BASE_OFF) && (int'(widx) < NWIN) && (off[1:0] == 2'b00);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    win_cfg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (cfg_we_i && sel && int'(widx) == g) begin
        if (!off[2]) begin
          q.en    <= cfg_wdata_i[31];
          q.trans <= cfg_wdata_i[15:0];
        end else begin
          q.base  <= cfg_wdata_i[31:16];
          q.mask  <= cfg_wdata_i[15:0];
        end
      end
    end
    assign cfg_o[g] = q;
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (sel && int'(widx) == i) begin
        cfg_rdata_o = off[2] ? {cfg_o[i].base, cfg_o[i].mask}
                             : {cfg_o[i].en, 15'b0, cfg_o[i].trans};
      end
    end
  end
endmodule

// File: rtl/pwr_window_match.sv
module pwr_window_match
  import pwr_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  win_cfg_t [NWIN-1:0] cfg_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [NWIN-1:0] hit_vec;
  logic [HI_W-1:0] hi;

  assign hi = addr_i[ADDR_W-1:HI_LSB];

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign hit_vec[g] = cfg_i[g].en && (((cfg_i[g].base ^ hi) & cfg_i[g].mask) == '0);
  end

  // descending scan: lowest index wins
  always_comb begin
    addr_o = addr_i;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        addr_o[ADDR_W-1:HI_LSB] = (cfg_i[i].trans & cfg_i[i].mask) | (hi & ~cfg_i[i].mask);
      end
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/pwr_txn_ctrl.sv
module pwr_txn_ctrl
  import pwr_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [STRB_W-1:0]   w_strb_i,
  output logic                b_valid_o,
  input  logic                b_ready_i,
  output logic [1:0]          b_resp_o,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic                cmd_posted_o,
  output logic [ADDR_W-1:0]   cmd_addr_o,
  output logic [DATA_W-1:0]   cmd_data_o,
  output logic [STRB_W-1:0]   cmd_strb_o,
  input  logic                cpl_valid_i,
  input  logic [1:0]          cpl_resp_i,
  output logic [ADDR_W-1:0]   addr_q_o,
  input  logic                route_hit_i,
  input  logic [ADDR_W-1:0]   route_addr_i
);
  logic              aw_have, w_have, wait_cpl, active, launch;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign active     = cmd_valid_o | b_valid_o | wait_cpl;
  assign aw_ready_o = !aw_have && !active;
  assign w_ready_o  = !w_have && !active;
  assign launch     = aw_have && w_have && !active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_have      <= 1'b0;
      w_have       <= 1'b0;
      addr_q_o     <= '0;
      data_q       <= '0;
      strb_q       <= '0;
      cmd_valid_o  <= 1'b0;
      cmd_posted_o <= 1'b0;
      cmd_addr_o   <= '0;
      cmd_data_o   <= '0;
      cmd_strb_o   <= '0;
      b_valid_o    <= 1'b0;
      b_resp_o     <= RESP_OKAY;
      wait_cpl     <= 1'b0;
    end else begin
      if (aw_valid_i && aw_ready_o) begin
        aw_have  <= 1'b1;
        addr_q_o <= aw_addr_i;
      end
      if (w_valid_i && w_ready_o) begin
        w_have <= 1'b1;
        data_q <= w_data_i;
        strb_q <= w_strb_i;
      end
      if (launch) begin
        aw_have      <= 1'b0;
        w_have       <= 1'b0;
        cmd_valid_o  <= 1'b1;
        cmd_posted_o <= route_hit_i;
        cmd_addr_o   <= route_addr_i;
        cmd_data_o   <= data_q;
        cmd_strb_o   <= strb_q;
        b_valid_o    <= route_hit_i;   // posted: early response
        b_resp_o     <= RESP_OKAY;
        wait_cpl     <= !route_hit_i;
      end
      if (cmd_valid_o && cmd_ready_i) cmd_valid_o <= 1'b0;
      if (b_valid_o && b_ready_i) b_valid_o <= 1'b0;
      if (wait_cpl && !cmd_valid_o && cpl_valid_i) begin
        wait_cpl  <= 1'b0;
        b_valid_o <= 1'b1;
        b_resp_o  <= cpl_resp_i;
      end
    end
  end
endmodule

// File: rtl/post_win_router.sv
module post_win_router
  import pwr_pkg::*;
#(
  parameter int                NWIN     = 2,
  parameter int                DATA_W   = 64,
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] BASE_OFF = 8'hd0,
  localparam int               STRB_W   = DATA_W / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [STRB_W-1:0]   w_strb_i,
  output logic                b_valid_o,
  input  logic                b_ready_i,
  output logic [1:0]          b_resp_o,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic                cmd_posted_o,
  output logic [ADDR_W-1:0]   cmd_addr_o,
  output logic [DATA_W-1:0]   cmd_data_o,
  output logic [STRB_W-1:0]   cmd_strb_o,
  input  logic                cpl_valid_i,
  input  logic [1:0]          cpl_resp_i
);
  win_cfg_t [NWIN-1:0] cfg;
  logic [ADDR_W-1:0]   addr_q, route_addr;
  logic                route_hit;

  pwr_regfile #(.NWIN(NWIN), .CFG_AW(CFG_AW), .BASE_OFF(BASE_OFF)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .cfg_o(cfg)
  );

  pwr_window_match #(.NWIN(NWIN)) u_match (
    .cfg_i(cfg), .addr_i(addr_q), .hit_o(route_hit), .addr_o(route_addr)
  );

  pwr_txn_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .aw_valid_i, .aw_ready_o, .aw_addr_i,
    .w_valid_i, .w_ready_o, .w_data_i, .w_strb_i,
    .b_valid_o, .b_ready_i, .b_resp_o,
    .cmd_valid_o, .cmd_ready_i, .cmd_posted_o, .cmd_addr_o, .cmd_data_o, .cmd_strb_o,
    .cpl_valid_i, .cpl_resp_i,
    .addr_q_o(addr_q), .route_hit_i(route_hit), .route_addr_i(route_addr)
  );
endmodule

// File: rtl/pwr_checker.sv
module pwr_checker #(
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] BASE_OFF = 8'hd0,
  parameter int                DATA_W   = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CFG_AW-1:0]   cfg_addr_i,
  input logic [31:0]         cfg_rdata_o,
  input logic                aw_ready_o,
  input logic                b_valid_o,
  input logic                b_ready_i,
  input logic [1:0]          b_resp_o,
  input logic                cmd_valid_o,
  input logic                cmd_ready_i,
  input logic                cmd_posted_o,
  input logic [39:0]         cmd_addr_o,
  input logic [DATA_W-1:0]   cmd_data_o,
  input logic [DATA_W/8-1:0] cmd_strb_o,
  input logic                cpl_valid_i
);
  logic np_wait;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) np_wait <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i && !cmd_posted_o) np_wait <= 1'b1;
    else if (cpl_valid_i) np_wait <= 1'b0;
  end

  a_r5_no_early_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    np_wait |-> !b_valid_o);
  a_r5_np_cmd_no_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_posted_o) |-> !b_valid_o);
  a_r4_posted_early_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_valid_o) && cmd_posted_o) |-> (b_valid_o && b_resp_o == 2'b00));
  a_r8_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || b_valid_o || np_wait) |-> !aw_ready_o);
  a_r8_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_o && !b_ready_i) |=> (b_valid_o && $stable(b_resp_o)));
  a_r9_cmd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o) &&
      $stable(cmd_data_o) && $stable(cmd_strb_o) && $stable(cmd_posted_o)));
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == BASE_OFF || cfg_addr_i == BASE_OFF + 8'd8) |-> (cfg_rdata_o[30:16] == '0));
endmodule

bind post_win_router pwr_checker #(.CFG_AW(CFG_AW), .BASE_OFF(BASE_OFF), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr_i), .cfg_rdata_o(cfg_rdata_o),
  .aw_ready_o(aw_ready_o), .b_valid_o(b_valid_o), .b_ready_i(b_ready_i), .b_resp_o(b_resp_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_posted_o(cmd_posted_o),
  .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o), .cmd_strb_o(cmd_strb_o),
  .cpl_valid_i(cpl_valid_i)
);

// File: tb/post_win_router_bench.sv
module post_win_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        aw_valid = 1'b0, w_valid = 1'b0, b_ready = 1'b0;
  logic        cmd_ready = 1'b0, cpl_valid = 1'b0;
  logic [39:0] aw_addr = '0;
  logic [63:0] w_data = '0;
  logic [7:0]  w_strb = '0;
  logic [1:0]  cpl_resp = '0;
  logic        aw_ready, w_ready, b_valid, cmd_valid, cmd_posted;
  logic [1:0]  b_resp;
  logic [39:0] cmd_addr;
  logic [63:0] cmd_data;
  logic [7:0]  cmd_strb;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the window registers
  logic        m_en [2];
  logic [15:0] m_tr [2], m_base [2], m_mask [2];

  always #10ns clk = ~clk;

  post_win_router u_post_win_router (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .aw_valid_i(aw_valid), .aw_ready_o(aw_ready), .aw_addr_i(aw_addr),
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_data_i(w_data), .w_strb_i(w_strb),
    .b_valid_o(b_valid), .b_ready_i(b_ready), .b_resp_o(b_resp),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_posted_o(cmd_posted),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .cmd_strb_o(cmd_strb),
    .cpl_valid_i(cpl_valid), .cpl_resp_i(cpl_resp)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(logic [39:0] a);
    for (int i = 0; i < 2; i++)
      if (m_en[i] && ((m_base[i] & m_mask[i]) == (a[39:24] & m_mask[i]))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [39:0] exp_addr(logic [39:0] a);
    for (int i = 0; i < 2; i++)
      if (m_en[i] && ((m_base[i] & m_mask[i]) == (a[39:24] & m_mask[i])))
        return {(m_tr[i] & m_mask[i]) | (a[39:24] & ~m_mask[i]), a[23:0]};
    return a;
  endfunction

  task automatic cfg_write(logic [7:0] off, logic [31:0] d);
    int w;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    w = (off - 8'hd0) >> 3;
    if (!off[2]) begin m_en[w] = d[31]; m_tr[w] = d[15:0]; end
    else begin m_base[w] = d[31:16]; m_mask[w] = d[15:0]; end
  endtask

  task automatic cfg_check(logic [7:0] off, logic [31:0] exp, string req);
    @(negedge clk);
    cfg_addr = off;
    #1ns;
    chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic xfer(logic [39:0] a, logic [63:0] d, logic [7:0] s,
                      int cmd_dly, int cpl_dly, logic [1:0] resp);
    bit posted;
    logic [39:0] ea;
    int n;
    posted = exp_hit(a);
    ea = exp_addr(a);
    @(negedge clk);
    aw_valid = 1'b1; w_valid = 1'b1; aw_addr = a; w_data = d; w_strb = s;
    n = 0;
    while (!(aw_ready && w_ready) && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    aw_valid = 1'b0; w_valid = 1'b0;
    n = 0;
    while (!cmd_valid && n < 10) begin @(negedge clk); n++; end
    chk(cmd_valid, "R9 cmd issued", 64'(cmd_valid), 64'd1);
    chk(cmd_posted == posted, posted ? "R4 posted flag" : "R5 nonposted flag",
        64'(cmd_posted), 64'(posted));
    chk(cmd_addr == ea, "R6 routed address", 64'(cmd_addr), 64'(ea));
    chk(cmd_data == d && cmd_strb == s, "R9 data/strobe", cmd_data, d);
    if (posted) chk(b_valid && b_resp == 2'b00, "R4 early B", 64'(b_valid), 64'd1);
    else        chk(!b_valid, "R5 no B before completion", 64'(b_valid), 64'd0);
    for (int i = 0; i < cmd_dly; i++) begin
      @(negedge clk);
      chk(cmd_valid && cmd_addr == ea && cmd_data == d, "R9 stable under stall",
          64'(cmd_addr), 64'(ea));
      chk(!aw_ready, "R8 stall", 64'(aw_ready), 64'd0);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    if (!posted) begin
      for (int i = 0; i < cpl_dly; i++) begin
        chk(!b_valid && !aw_ready, "R5 B held for completion", 64'(b_valid), 64'd0);
        @(negedge clk);
      end
      cpl_valid = 1'b1; cpl_resp = resp;
      @(negedge clk);
      cpl_valid = 1'b0;
      chk(b_valid && b_resp == resp, "R5 B after completion", 64'(b_resp), 64'(resp));
    end else begin
      chk(b_valid, "R8 B held until accepted", 64'(b_valid), 64'd1);
    end
    b_ready = 1'b1;
    @(negedge clk);
    b_ready = 1'b0;
    chk(!b_valid && aw_ready, "R8 idle after B", 64'(aw_ready), 64'd1);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_tr[i] = 0; m_base[i] = 0; m_mask[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, unprogrammed windows route non-posted
    cfg_check(8'hd0, 32'h0, "R1 reset d0");
    cfg_check(8'hd4, 32'h0, "R1 reset d4");
    cfg_check(8'hd8, 32'h0, "R1 reset d8");
    cfg_check(8'hdc, 32'h0, "R1 reset dc");
    xfer(40'h00_0000_1000, 64'h1122334455667788, 8'hff, 0, 2, 2'b00);
    // R2: field layout, reserved bits
    cfg_write(8'hd0, 32'hffff_ffff);
    cfg_check(8'hd0, 32'h8000_ffff, "R2 reserved zero");
    cfg_write(8'hd4, 32'h1200_ff00);
    cfg_check(8'hd4, 32'h1200_ff00, "R2 base/mask");
    cfg_write(8'hd0, 32'h8000_ab00);
    cfg_write(8'hdc, 32'h1230_fff0);
    cfg_write(8'hd8, 32'h8000_5550);
    cfg_check(8'hd8, 32'h8000_5550, "R2 win1 enable/trans");
    // R7: both hit, window 0 wins -> ab34
    xfer(40'h12_34_56789a, 64'hdead_beef_0000_0001, 8'h0f, 2, 0, 2'b00);
    // R3/R6: window 0 only
    xfer(40'h12_40_000000, 64'h2, 8'h01, 0, 0, 2'b00);
    // R5: miss with error completion
    xfer(40'h99_00_000010, 64'h3, 8'hf0, 1, 3, 2'b10);
    // R10: window 0 disabled -> window 1 -> 5554
    cfg_write(8'hd0, 32'h0000_ab00);
    xfer(40'h12_34_000000, 64'h4, 8'hff, 0, 0, 2'b00);
    // R10: window 1 disabled too -> miss
    cfg_write(8'hd8, 32'h0000_5550);
    xfer(40'h12_34_000000, 64'h5, 8'hff, 0, 1, 2'b00);
    // random windows with contiguous masks
    for (int t = 0; t < 300; t++) begin
      if (t % 20 == 0) begin
        for (int w = 0; w < 2; w++) begin
          cfg_write(8'hd4 + 8'(w * 8), {16'($urandom), 16'hffff << ($urandom % 17)});
          cfg_write(8'hd0 + 8'(w * 8), {1'($urandom % 4 != 0), 15'($urandom), 16'($urandom)});
        end
      end
      a = {$urandom, $urandom} & 40'hff_ffff_ffff;
      if ($urandom % 2) a[39:24] = m_base[$urandom % 2] ^ 16'($urandom % 4);
      xfer(a, {$urandom, $urandom}, 8'($urandom), $urandom % 3, $urandom % 4, 2'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule